// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address for a paged memory system with 4 KB pages. It reads one directory entry and then one second-level entry through a single 32-bit memory port. The directory location comes from a frame-number input that holds bits 31:12 of the directory base. On the way through, the walker marks each entry it uses as accessed. On a write it also marks the final entry as dirty. It checks presence and the write and user permissions. When a check fails it reports a page fault with an error code and latches the faulting linear address. When the paging-enable input is low, the address passes through unchanged and no memory is touched.

A requester presents an address, a write flag and a user flag with `req_valid` while `req_ready` is high. The walker takes the paging enable and the directory frame at that moment. Exactly one response pulse follows later, carrying either the physical address or a fault.

States: `S_IDLE` (waiting for a request), `S_DIR_RD` (directory entry read), `S_DIR_WB` (directory accessed-flag write-back), `S_TBL_RD` (second-level entry read and permission check), `S_TBL_WB` (final entry flag write-back), `S_DONE` (success pulse), `S_FAULT` (fault pulse).

Transitions:
- `S_IDLE`→`S_DONE` when the request arrives with paging off.
- `S_IDLE`→`S_DIR_RD` when it arrives with paging on.
- `S_DIR_RD`→`S_FAULT` on a non-present entry. `S_DIR_RD`→`S_DIR_WB` when the accessed flag is clear. `S_DIR_RD`→`S_TBL_RD` otherwise.
- `S_DIR_WB`→`S_TBL_RD` once the write is taken.
- `S_TBL_RD`→`S_FAULT` on a non-present entry or a permission miss. `S_TBL_RD`→`S_TBL_WB` when a flag must change. `S_TBL_RD`→`S_DONE` otherwise.
- `S_TBL_WB`→`S_DONE` once the write is taken.
- `S_DONE`→`S_IDLE` and `S_FAULT`→`S_IDLE` after one cycle.

Top module: `pt_walker`

## Requirements
- R1: After reset `req_ready` is 1, `resp_valid` and `mem_valid` are 0, and `fault_addr` is 0.
- R2: With paging disabled at acceptance, `resp_valid` rises in the cycle after acceptance with `resp_fault`=0 and `resp_paddr` equal to the linear address, and no memory transaction occurs.
- R3: The directory entry address is {dir_frame, lin[31:22], 2'b00}. The second-level entry address is {directory entry bits 31:12, lin[21:12], 2'b00}. `dir_frame` and `pg_en` are used as sampled at acceptance.
- R4: On success `resp_paddr` is {final entry bits 31:12, lin[11:0]}.
- R5: An entry with bit 0 (present) clear at either level ends the walk with a fault and error-code bit 0 = 0. No further memory transaction follows.
- R6: A user access (`req_user`=1) needs bit 2 set in both entries. A user write also needs bit 1 set in both entries. Supervisor accesses ignore both bits. A miss is a fault with error-code bit 0 = 1 and no write-back of the final entry.
- R7: Error-code bit 1 equals the write flag. Error-code bit 2 is 1 when the access is supervisor (`req_user`=0).
- R8: Each entry used is written back with bit 5 (accessed) set when it was clear. An entry whose flags need no change is not written.
- R9: Bit 6 (dirty) is set only in the final entry and only on a write, in the same write-back as the accessed flag, before the response.
- R10: `fault_addr` takes the linear address on every fault and holds its value across successful walks.
- R11: A memory request keeps `mem_valid`, `mem_addr`, `mem_we` and `mem_wdata` stable until `mem_ready`. Each handshake is one transaction: a read in the order directory then table, with each write-back directly after its read.
- R12: `req_ready` is high only while idle, and each accepted request yields exactly one single-cycle `resp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pg_en | input | 1 | Paging enable, sampled at acceptance |
| dir_frame | input | 20 | Directory base frame (base bits 31:12) |
| req_valid | input | 1 | Translation request |
| req_addr | input | 32 | Linear address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user level |
| req_ready | output | 1 | Walker idle, request accepted |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_fault | output | 1 | Response is a page fault |
| resp_paddr | output | 32 | Physical address on success |
| fault_code | output | 3 | Page-fault error code |
| fault_addr | output | 32 | Last faulting linear address |
| mem_valid | output | 1 | Memory transaction request |
| mem_we | output | 1 | Transaction is a write |
| mem_addr | output | 32 | Entry byte address |
| mem_wdata | output | 32 | Entry write data |
| mem_ready | input | 1 | Transaction accepted; read data valid |
| mem_rdata | input | 32 | Entry read data |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the accessed and dirty updates of the final entry. A write to an entry with both flags clear has to produce one write-back carrying both bits, not two separate writes. The second pair is a walk in flight and a change of the directory frame and paging enable. The bench flips both inputs in the cycle after acceptance and expects the walk to keep the values captured at acceptance. A behavioural model predicts every memory transaction and the response. Each handshake is compared against that prediction while the memory inserts random wait cycles.

// File: rtl/pw_pkg.sv
package pw_pkg;
    localparam int BIT_PRESENT = 0;
    localparam int BIT_RW      = 1;
    localparam int BIT_USER    = 2;
    localparam int BIT_ACC     = 5;
    localparam int BIT_DIRTY   = 6;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DIR_RD,
        S_DIR_WB,
        S_TBL_RD,
        S_TBL_WB,
        S_DONE,
        S_FAULT
    } walk_st_t;
endpackage

// File: rtl/pw_addr.sv
module pw_addr #(
    parameter  int IDX_W = 10,
    parameter  int OFF_W = 12,
    localparam int AW    = 2 * IDX_W + OFF_W,
    localparam int FW    = AW - OFF_W,
    localparam int PAD_W = OFF_W - IDX_W
) (
    input  logic [FW-1:0]    frame,
    input  logic [IDX_W-1:0] idx,
    output logic [AW-1:0]    addr
);
    // entry index scaled by the entry size inside a page-aligned table
    assign addr = {frame, idx, {PAD_W{1'b0}}};
endmodule

// File: rtl/pw_perm.sv
module pw_perm (
    input  logic upper_rw,
    input  logic upper_us,
    input  logic lower_rw,
    input  logic lower_us,
    input  logic is_write,
    input  logic is_user,
    output logic allow
);
    logic both_rw, both_us;
    assign both_rw = upper_rw & lower_rw;
    assign both_us = upper_us & lower_us;
    assign allow   = !is_user || (both_us && (!is_write || both_rw));
endmodule

// File: rtl/pw_upd.sv
module pw_upd #(
    parameter int W = 32
) (
    input  logic [W-1:0] entry,
    input  logic         set_dirty,
    output logic [W-1:0] new_entry,
    output logic         need_wb
);
    import pw_pkg::*;
    logic [W-1:0] mask;
    always_comb begin
        mask = '0;
        mask[BIT_ACC]   = 1'b1;
        mask[BIT_DIRTY] = set_dirty;
    end
    assign new_entry = entry | mask;
    assign need_wb   = (new_entry != entry);
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
    parameter  int IDX_W = 10,
    parameter  int OFF_W = 12,
    localparam int AW    = 2 * IDX_W + OFF_W,
    localparam int FW    = AW - OFF_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pg_en,
    input  logic [FW-1:0] dir_frame,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic          req_write,
    input  logic          req_user,
    output logic          req_ready,
    output logic          resp_valid,
    output logic          resp_fault,
    output logic [AW-1:0] resp_paddr,
    output logic [2:0]    fault_code,
    output logic [AW-1:0] fault_addr,
    output logic          mem_valid,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] mem_wdata,
    input  logic          mem_ready,
    input  logic [AW-1:0] mem_rdata
);
    import pw_pkg::*;

    localparam int LVLS = 2;

    walk_st_t      st, st_nx;
    logic [AW-1:0] lin_q, pde_q, pte_q, paddr_q, cr2_q;
    logic [FW-1:0] base_q;
    logic          wr_q, usr_q;
    logic [2:0]    code_q;

    logic [AW-1:0] dir_addr, tbl_addr;
    logic [AW-1:0] upd_val [LVLS];
    logic          upd_need[LVLS];
    logic          allow;
    logic          accept;

    assign accept = req_valid && (st == S_IDLE);

    pw_addr #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_dir_addr (
        .frame(base_q),
        .idx  (lin_q[AW-1 -: IDX_W]),
        .addr (dir_addr)
    );

    pw_addr #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_tbl_addr (
        .frame(pde_q[AW-1:OFF_W]),
        .idx  (lin_q[OFF_W+IDX_W-1:OFF_W]),
        .addr (tbl_addr)
    );

    // level 0 = directory (accessed only), level 1 = final entry (accessed + dirty on write)
    for (genvar g = 0; g < LVLS; g++) begin : g_upd
        pw_upd #(.W(AW)) u_upd (
            .entry    (mem_rdata),
            .set_dirty((g == LVLS - 1) ? wr_q : 1'b0),
            .new_entry(upd_val[g]),
            .need_wb  (upd_need[g])
        );
    end

    pw_perm u_perm (
        .upper_rw(pde_q[BIT_RW]),
        .upper_us(pde_q[BIT_USER]),
        .lower_rw(mem_rdata[BIT_RW]),
        .lower_us(mem_rdata[BIT_USER]),
        .is_write(wr_q),
        .is_user (usr_q),
        .allow   (allow)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:   if (req_valid) st_nx = pg_en ? S_DIR_RD : S_DONE;
            S_DIR_RD: if (mem_ready) begin
                          if (!mem_rdata[BIT_PRESENT]) st_nx = S_FAULT;
                          else if (upd_need[0])        st_nx = S_DIR_WB;
                          else                         st_nx = S_TBL_RD;
                      end
            S_DIR_WB: if (mem_ready) st_nx = S_TBL_RD;
            S_TBL_RD: if (mem_ready) begin
                          if (!mem_rdata[BIT_PRESENT] || !allow) st_nx = S_FAULT;
                          else if (upd_need[1])                  st_nx = S_TBL_WB;
                          else                                   st_nx = S_DONE;
                      end
            S_TBL_WB: if (mem_ready) st_nx = S_DONE;
            S_DONE:   st_nx = S_IDLE;
            S_FAULT:  st_nx = S_IDLE;
            default:  st_nx = S_IDLE;
        endcase
    end

    // walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lin_q   <= '0;
            base_q  <= '0;
            wr_q    <= 1'b0;
            usr_q   <= 1'b0;
            pde_q   <= '0;
            pte_q   <= '0;
            paddr_q <= '0;
            cr2_q   <= '0;
            code_q  <= '0;
        end else begin
            if (accept) begin
                lin_q   <= req_addr;
                base_q  <= dir_frame;
                wr_q    <= req_write;
                usr_q   <= req_user;
                paddr_q <= req_addr;
            end
            if (st == S_DIR_RD && mem_ready) begin
                pde_q <= upd_val[0];
                if (!mem_rdata[BIT_PRESENT]) begin
                    code_q <= {~usr_q, wr_q, 1'b0};
                    cr2_q  <= lin_q;
                end
            end
            if (st == S_TBL_RD && mem_ready) begin
                pte_q   <= upd_val[1];
                paddr_q <= {mem_rdata[AW-1:OFF_W], lin_q[OFF_W-1:0]};
                if (!mem_rdata[BIT_PRESENT] || !allow) begin
                    code_q <= {~usr_q, wr_q, mem_rdata[BIT_PRESENT]};
                    cr2_q  <= lin_q;
                end
            end
        end
    end

    // outputs
    always_comb begin
        req_ready  = 1'b0;
        resp_valid = 1'b0;
        resp_fault = 1'b0;
        mem_valid  = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        unique case (st)
            S_IDLE:   req_ready = 1'b1;
            S_DIR_RD: begin mem_valid = 1'b1; mem_addr = dir_addr; end
            S_DIR_WB: begin mem_valid = 1'b1; mem_we = 1'b1; mem_addr = dir_addr; mem_wdata = pde_q; end
            S_TBL_RD: begin mem_valid = 1'b1; mem_addr = tbl_addr; end
            S_TBL_WB: begin mem_valid = 1'b1; mem_we = 1'b1; mem_addr = tbl_addr; mem_wdata = pte_q; end
            S_DONE:   resp_valid = 1'b1;
            S_FAULT:  begin resp_valid = 1'b1; resp_fault = 1'b1; end
            default:  req_ready = 1'b0;
        endcase
    end

    assign resp_paddr = paddr_q;
    assign fault_code = code_q;
    assign fault_addr = cr2_q;

    AST_BYPASS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !pg_en) |=> (resp_valid && !resp_fault && resp_paddr == $past(req_addr))); // R2
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R11
    AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_we) |-> mem_wdata[BIT_ACC]); // R8
    AST_DIRTY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_TBL_WB && wr_q) |-> mem_wdata[BIT_DIRTY]); // R9
    AST_FAULT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault) |-> (fault_addr == lin_q)); // R10
    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid); // R12
    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault) |-> !mem_valid); // R5
endmodule

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pg_en = 1'b1;
    logic [19:0] dir_frame = 20'h00100;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        req_ready, resp_valid, resp_fault;
    logic [31:0] resp_paddr, fault_addr, mem_addr, mem_wdata;
    logic [2:0]  fault_code;
    logic        mem_valid, mem_we;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #10 clk = ~clk;

    pt_walker dut (
        .clk(clk), .rst_n(rst_n), .pg_en(pg_en), .dir_frame(dir_frame),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .req_user(req_user), .req_ready(req_ready), .resp_valid(resp_valid),
        .resp_fault(resp_fault), .resp_paddr(resp_paddr), .fault_code(fault_code),
        .fault_addr(fault_addr), .mem_valid(mem_valid), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata)
    );

    typedef struct {
        bit          we;
        logic [31:0] addr;
        logic [31:0] data;
        string       tag;
    } txn_t;

    txn_t        exp_q[$];
    logic [31:0] mem [logic [31:0]];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          got_resp = 0;
    bit          exp_fault;
    logic [31:0] exp_paddr;
    logic [31:0] exp_cr2 = '0;
    logic [2:0]  exp_code;
    string       exp_tag;
    int          stall = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [31:0] rdw(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // behavioural model of one walk
    task automatic model(input logic [31:0] a, input bit wr, input bit us, input bit pg, input logic [19:0] fr);
        logic [31:0] pa, pe, ta, te, nv;
        bit ok;
        exp_fault = 0;
        if (!pg) begin
            exp_paddr = a;
            exp_tag = "R2 bypass address";
            return;
        end
        pa = {fr, a[31:22], 2'b00};
        pe = rdw(pa);
        exp_q.push_back('{0, pa, 32'h0, "R3 directory read"});
        if (!pe[0]) begin
            exp_fault = 1; exp_code = {~us, wr, 1'b0}; exp_cr2 = a;
            return;
        end
        if (!pe[5]) exp_q.push_back('{1, pa, pe | 32'h20, "R8 directory accessed write-back"});
        ta = {pe[31:12], a[21:12], 2'b00};
        te = rdw(ta);
        exp_q.push_back('{0, ta, 32'h0, "R3 table read"});
        if (!te[0]) begin
            exp_fault = 1; exp_code = {~us, wr, 1'b0}; exp_cr2 = a;
            return;
        end
        ok = !us || ((pe[2] && te[2]) && (!wr || (pe[1] && te[1])));
        if (!ok) begin
            exp_fault = 1; exp_code = {~us, wr, 1'b1}; exp_cr2 = a;
            return;
        end
        nv = te | 32'h20 | (wr ? 32'h40 : 32'h0);
        if (nv != te) exp_q.push_back('{1, ta, nv, "R9 final entry flag write-back"});
        exp_paddr = {te[31:12], a[11:0]};
        exp_tag = "R4 physical address";
    endtask

    // per-clock monitor and memory model
    always @(negedge clk) begin
        if (rst_n) begin
            chk(!(mem_valid && req_ready), "R12 ready while walking", {31'h0, req_ready}, 32'h0);
            if (mem_ready) begin
                mem_ready = 1'b0;
                stall = $urandom_range(0, 2);
            end else if (mem_valid) begin
                if (stall > 0) stall--;
                else begin
                    if (exp_q.size() == 0) begin
                        chk(0, "R11 unexpected memory transaction", mem_addr, 32'h0);
                    end else begin
                        txn_t h;
                        h = exp_q.pop_front();
                        chk(mem_addr == h.addr && mem_we == h.we, {h.tag, " address/kind"}, mem_addr, h.addr);
                        if (h.we) chk(mem_wdata == h.data, {h.tag, " data"}, mem_wdata, h.data);
                    end
                    if (mem_we) mem[mem_addr] = mem_wdata;
                    mem_rdata = rdw(mem_addr);
                    mem_ready = 1'b1;
                end
            end
            if (resp_valid) begin
                got_resp = 1;
                chk(exp_q.size() == 0, "R5 walk ended with transactions pending", exp_q.size(), 32'h0);
                exp_q.delete();
                chk(resp_fault == exp_fault, "R5/R6 fault flag", {31'h0, resp_fault}, {31'h0, exp_fault});
                if (exp_fault)
                    chk(fault_code == exp_code, "R7 error code", {29'h0, fault_code}, {29'h0, exp_code});
                else
                    chk(resp_paddr == exp_paddr, exp_tag, resp_paddr, exp_paddr);
                chk(fault_addr == exp_cr2, "R10 fault address register", fault_addr, exp_cr2);
            end
        end
    end

    task automatic issue(input logic [31:0] a, input bit wr, input bit us, input bit pg, input bit flip);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        got_resp  = 0;
        req_addr  = a;
        req_write = wr;
        req_user  = us;
        pg_en     = pg;
        req_valid = 1'b1;
        model(a, wr, us, pg, dir_frame);
        @(negedge clk);
        req_valid = 1'b0;
        if (flip) begin
            dir_frame = 20'hABCDE;
            pg_en     = ~pg;
        end
        while (!got_resp) @(negedge clk);
        dir_frame = 20'h00100;
        pg_en     = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        mem[32'h0010_0004] = 32'h0020_0027;
        mem[32'h0020_000C] = 32'h0030_0007;
        mem[32'h0010_0008] = 32'h0021_0007;
        mem[32'h0021_0000] = 32'h0040_0067;
        mem[32'h0010_000C] = 32'h0022_0023;
        mem[32'h0022_0000] = 32'h0050_0027;
        mem[32'h0010_0010] = 32'h0023_0025;
        mem[32'h0023_0000] = 32'h0060_0067;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 req_ready after reset", {31'h0, req_ready}, 32'h1);
        chk(resp_valid == 1'b0, "R1 resp_valid after reset", {31'h0, resp_valid}, 32'h0);
        chk(mem_valid == 1'b0, "R1 mem_valid after reset", {31'h0, mem_valid}, 32'h0);
        chk(fault_addr == 32'h0, "R1 fault_addr after reset", fault_addr, 32'h0);

        issue(32'h0040_3499, 0, 1, 1, 0); // R8 final entry accessed set
        issue(32'h0040_3499, 0, 1, 1, 0); // R8 no write when flags already set
        issue(32'h0040_3499, 1, 1, 1, 0); // R9 dirty on write
        issue(32'h1234_5678, 0, 0, 0, 0); // R2 bypass
        issue(32'h0080_0010, 0, 0, 1, 0); // R8 directory accessed write-back
        issue(32'h0140_0000, 0, 1, 1, 0); // R5 directory not present, code 000
        issue(32'h0140_0ABC, 1, 0, 1, 0); // R7 code 110
        issue(32'h0040_5000, 0, 1, 1, 0); // R5 table not present
        issue(32'h00C0_0123, 0, 1, 1, 0); // R6 user bit clear in directory
        issue(32'h00C0_0123, 1, 0, 1, 0); // R6 supervisor ignores bits, R9 dirty
        issue(32'h0100_0FFF, 1, 1, 1, 0); // R6 read-only user write, code 011
        issue(32'h0100_0FFF, 0, 1, 1, 0); // R10 holds across success
        issue(32'h0080_0777, 1, 0, 1, 1); // R3 inputs flipped mid-walk
        issue(32'h0000_0042, 0, 0, 0, 1); // R2 bypass with flipped inputs

        for (int i = 0; i < 40; i++) begin
            logic [31:0] a;
            a = {$urandom_range(0, 6), 22'h0} | {$urandom_range(0, 3), 12'h0} | $urandom_range(0, 4095);
            issue(a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), ($urandom_range(0, 5) != 0), 1'($urandom_range(0, 1)));
        end

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule